// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers level-sensitive interrupt requests from peripheral sources and folds them onto 64 numbered request channels. A per-source mapping register picks the channel that each source drives. Several sources may point at the same channel, and the channel is then active while any one of them requests. Each channel has an enable bit and a class bit. The class bit steers the channel to the fast output or to the normal output.

For each output, a fixed-priority resolver picks the lowest-numbered enabled channel that is pending. The output then presents that channel's index, a flag that says nothing is pending, and a vector word taken from a 64-entry programmable table. Channels 0 and 1 are non-maskable. The fast path has no global gate: an enabled fast channel that is pending always drives the fast output. Software programs the block through a write-only port. An 8-bit address carries a region in bits [7:6] and an index in bits [5:0].

Top module: `vpic_core`

## Requirements
- R1: After reset, source n drives channel n, only channels 0 and 1 are enabled, every channel is in the normal class, every vector is zero, and both outputs report nothing pending.
- R2: A write to region 0 at index s sets the channel of source s to wr_data[5:0]. A channel fed by several sources is active while any of them requests.
- R3: Requests are sampled on the clock edge. A change on src_req does not reach the outputs before the next rising edge.
- R4: A write to region 2 loads the enable bits: index 0 covers channels 0..31 and index 1 covers channels 32..63, with bit k of wr_data standing for the channel 32*index+k. A channel whose bit is 0 never reaches either output.
- R5: Channels 0 and 1 stay enabled whatever value region 2 receives.
- R6: A write to region 3 loads the class bits with the same word layout as R4, where 1 selects the fast output and 0 selects the normal output. fiq is high while any enabled fast-class channel is active, and irq is high while any enabled normal-class channel is active.
- R7: Each output reports the lowest-numbered enabled active channel of its own class, independently of the other output.
- R8: A write to region 1 at index c stores wr_data as the vector of channel c. Each output presents the vector of its winning channel. When nothing is pending, the channel and the vector read zero and the none flag is high.
- R9: A register write that is applied on one clock edge is reflected at the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NSRC | Level requests from the sources |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Region [7:6], index [5:0] |
| wr_data | input | VW | Write data |
| fiq | output | 1 | Fast request pending |
| fiq_none | output | 1 | No fast channel pending |
| fiq_chan | output | 6 | Winning fast channel |
| fiq_vec | output | VW | Vector of winning fast channel |
| irq | output | 1 | Normal request pending |
| irq_none | output | 1 | No normal channel pending |
| irq_chan | output | 6 | Winning normal channel |
| irq_vec | output | VW | Vector of winning normal channel |

## Verification
A corrupted mapping, enable or class bit shows up one edge after the affected source next requests. The winning index then names the wrong channel, or the wrong output rises, or an output stays silent. A wrong vector entry appears only while its channel wins, so each checked vector is written and then read back through a winning request. The stimulus places competing channels on both outputs at once, so that a resolver which looks past its own class would be exposed on the same cycle.

// File: rtl/vpic_core.sv
module vpic_core #(
  parameter int NSRC = 64,
  parameter int NCH  = 64,
  parameter int VW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic            wr_en,
  input  logic [7:0]      wr_addr,
  input  logic [VW-1:0]   wr_data,
  output logic            fiq,
  output logic            fiq_none,
  output logic [5:0]      fiq_chan,
  output logic [VW-1:0]   fiq_vec,
  output logic            irq,
  output logic            irq_none,
  output logic [5:0]      irq_chan,
  output logic [VW-1:0]   irq_vec
);
  localparam int IW = $clog2(NCH);
  localparam int NW = NCH / 32;
  localparam logic [NCH-1:0] NMI = NCH'(3);

  logic [NSRC-1:0] req_q;
  logic [IW-1:0]   map_q [NSRC];
  logic [VW-1:0]   vec_q [NCH];
  logic [NCH-1:0]  en_q, cls_q, act, fset, iset;

  wire [1:0] region = wr_addr[7:6];
  wire [5:0] idx    = wr_addr[5:0];

  function automatic logic [IW-1:0] lowest(input logic [NCH-1:0] v);
    lowest = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (v[i]) lowest = i[IW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      en_q  <= NMI;
      cls_q <= '0;
      for (int s = 0; s < NSRC; s++) map_q[s] <= IW'(s % NCH);
      for (int c = 0; c < NCH; c++) vec_q[c] <= '0;
    end else begin
      req_q <= src_req;
      if (wr_en) begin
        for (int s = 0; s < NSRC; s++)
          if (region == 2'd0 && idx == 6'(s)) map_q[s] <= wr_data[IW-1:0];
        for (int c = 0; c < NCH; c++)
          if (region == 2'd1 && idx == 6'(c)) vec_q[c] <= wr_data;
        for (int w = 0; w < NW; w++) begin
          if (region == 2'd2 && idx == 6'(w)) en_q[w*32 +: 32]  <= wr_data[31:0];
          if (region == 2'd3 && idx == 6'(w)) cls_q[w*32 +: 32] <= wr_data[31:0];
        end
      end
    end
  end

  always_comb begin
    act = '0;
    for (int s = 0; s < NSRC; s++)
      if (req_q[s]) act[map_q[s]] = 1'b1;
  end

  assign fset = act & (en_q | NMI) & cls_q;
  assign iset = act & (en_q | NMI) & ~cls_q;

  assign fiq      = |fset;
  assign irq      = |iset;
  assign fiq_none = ~fiq;
  assign irq_none = ~irq;
  assign fiq_chan = 6'(lowest(fset));
  assign irq_chan = 6'(lowest(iset));
  assign fiq_vec  = fiq ? vec_q[fiq_chan[IW-1:0]] : '0;
  assign irq_vec  = irq ? vec_q[irq_chan[IW-1:0]] : '0;
endmodule

module vpic_checker #(
  parameter int NSRC = 64,
  parameter int VW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_req,
  input logic            wr_en,
  input logic            fiq,
  input logic            fiq_none,
  input logic [5:0]      fiq_chan,
  input logic [VW-1:0]   fiq_vec,
  input logic            irq,
  input logic            irq_none,
  input logic [5:0]      irq_chan,
  input logic [VW-1:0]   irq_vec
);
  logic [1:0] edges;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) edges <= '0;
    else if (edges != 2'd3) edges <= edges + 2'd1;

  a_r8_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_none |-> (fiq_chan == 6'd0 && fiq_vec == '0)) and
    (irq_none |-> (irq_chan == 6'd0 && irq_vec == '0)));

  a_r6_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq && irq) |-> (fiq_chan != irq_chan));

  a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (edges != 2'd0 && $past(src_req) == '0) |-> (fiq_none && irq_none));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (edges >= 2'd2 && $past(src_req) == $past(src_req, 2) && !$past(wr_en))
      |-> ($stable(fiq_chan) && $stable(irq_chan) && $stable(fiq) && $stable(irq)));
endmodule

bind vpic_core vpic_checker #(.NSRC(NSRC), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_req(src_req), .wr_en(wr_en),
  .fiq(fiq), .fiq_none(fiq_none), .fiq_chan(fiq_chan), .fiq_vec(fiq_vec),
  .irq(irq), .irq_none(irq_none), .irq_chan(irq_chan), .irq_vec(irq_vec));

// File: tb/sim_vpic_core.sv
`timescale 1ns/1ps
module sim_vpic_core;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] src_req = '0;
  logic        wr_en = 0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        fiq, fiq_none, irq, irq_none;
  logic [5:0]  fiq_chan, irq_chan;
  logic [31:0] fiq_vec, irq_vec;

  vpic_core u0 (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [5:0]  map_m [64];
  logic [31:0] vec_m [64];
  logic [63:0] en_m, cls_m, req_m;
  logic [77:0] expq [$];
  string       tagq [$];
  logic [77:0] last_exp;

  function automatic logic [77:0] model();
    logic [63:0] act, f, n;
    logic [5:0] fc, ic;
    act = '0; fc = '0; ic = '0;
    for (int s = 0; s < 64; s++) if (req_m[s]) act[map_m[s]] = 1'b1;
    f = act & (en_m | 64'd3) & cls_m;
    n = act & (en_m | 64'd3) & ~cls_m;
    for (int i = 63; i >= 0; i--) begin
      if (f[i]) fc = 6'(i);
      if (n[i]) ic = 6'(i);
    end
    return {|f, fc, (|f) ? vec_m[fc] : 32'd0, |n, ic, (|n) ? vec_m[ic] : 32'd0};
  endfunction

  function automatic logic [77:0] observed();
    return {fiq, fiq_chan, fiq_vec, irq, irq_chan, irq_vec};
  endfunction

  task automatic step(input logic [63:0] src, input bit we, input logic [7:0] a,
                      input logic [31:0] d, input string tag, input bit hold_chk = 0);
    @(negedge clk);
    src_req = src; wr_en = we; wr_addr = a; wr_data = d;
    if (hold_chk) begin
      #1;
      checks++;
      if (observed() !== last_exp) begin
        errors++;
        $display("FAIL %s: outputs moved before edge, got %h expected %h", tag, observed(), last_exp);
      end
    end
    @(posedge clk);
    req_m = src;
    if (we) begin
      case (a[7:6])
        2'd0: map_m[a[5:0]] = d[5:0];
        2'd1: vec_m[a[5:0]] = d;
        2'd2: if (a[5:0] < 2) en_m[a[0]*32 +: 32] = d;
        2'd3: if (a[5:0] < 2) cls_m[a[0]*32 +: 32] = d;
      endcase
    end
    #1;
    last_exp = model();
    expq.push_back(last_exp);
    tagq.push_back(tag);
  endtask

  always @(negedge clk) begin
    while (expq.size() > 0) begin
      logic [77:0] e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      checks++;
      if (observed() !== e || fiq_none !== ~e[77] || irq_none !== ~e[38]) begin
        errors++;
        $display("FAIL %s: got %h none=%b%b expected %h", t, observed(), fiq_none, irq_none, e);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 64; s++) begin map_m[s] = 6'(s); vec_m[s] = '0; end
    en_m = 64'd3; cls_m = '0; req_m = '0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (fiq !== 0 || irq !== 0 || fiq_none !== 1 || irq_none !== 1 || fiq_chan !== 0 || irq_chan !== 0) begin
      errors++;
      $display("FAIL R1: reset outputs %h expected all idle", observed());
    end
    @(negedge clk); rst_n = 1;
    last_exp = model();
    step(64'd1 << 5, 0, 8'h00, 0, "R1 channel 5 disabled at reset");
    step(64'd1,      0, 8'h00, 0, "R1 identity map channel 0");
    step(64'd1,      1, {2'd1, 6'd0}, 32'hA0A0_0001, "R8 vector ch0");
    step(64'd1 << 5, 1, {2'd2, 6'd0}, 32'hFFFF_FFFF, "R9 enable write same edge");
    step(64'h23,     1, {2'd2, 6'd0}, 32'h0, "R5 ch0 survives mask clear");
    step(64'h22,     0, 8'h00, 0, "R5 ch1 survives, R4 ch5 masked");
    step(64'h20,     0, 8'h00, 0, "R4 masked channel alone");
    step(64'h0,      1, {2'd2, 6'd0}, 32'hFFFF_FFFF, "R4 enable low word");
    step(64'h0,      1, {2'd2, 6'd1}, 32'hFFFF_FFFF, "R4 enable high word");
    step(64'h0,      1, {2'd3, 6'd1}, 32'h0000_0100, "R6 ch40 fast");
    step((64'd1 << 40) | (64'd1 << 50), 1, {2'd1, 6'd40}, 32'h4040_4040, "R6 split outputs");
    step((64'd1 << 63) | (64'd1 << 12) | (64'd1 << 30), 0, 8'h00, 0, "R7 lowest normal wins");
    step((64'd1 << 63) | (64'd1 << 12) | (64'd1 << 40), 1, {2'd3, 6'd1}, 32'h8000_0100, "R7 fast 40 over 63");
    step(64'd1 << 7, 0, 8'h00, 0, "R3 request held until edge", 1);
    step(64'd0,      1, {2'd0, 6'd60}, 32'd3, "R2 remap 60 to ch3");
    step(64'd1 << 60, 1, {2'd1, 6'd3}, 32'h0303_0303, "R2 source 60 drives ch3");
    step(64'd1 << 61, 1, {2'd0, 6'd61}, 32'd3, "R2 remap 61 same edge");
    step((64'd1 << 60) | (64'd1 << 61), 0, 8'h00, 0, "R2 shared channel");
    step(64'd1 << 3, 0, 8'h00, 0, "R2 native source 3 still ch3");
    step(64'd1 << 61, 1, {2'd0, 6'd61}, 32'd9, "R2 remap to ch9");
    step(64'd0,      0, 8'h00, 0, "R8 none gives zero vector");
    step(64'd1 << 63, 1, {2'd3, 6'd1}, 32'h8000_0000, "R6 ch63 fast, ch40 normal");
    step((64'd1 << 63) | (64'd1 << 40) | 64'd1, 0, 8'h00, 0, "R7 both outputs busy");
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule